// File: doc/BRIEF.md
# Three-Wire Register Write Port

This block is the configuration port of a sensor front end. A host shifts 16-bit frames into it over a serial clock, a data line and an active-low select. A static polarity input says whether the serial clock rests high or low. Each frame carries a 4-bit register address and a 10-bit value. The value lands in one of eight registers, each with a fixed reset default.

The registers are decoded into plain control outputs: gain code, two 8-bit user DAC codes, black-level target, input mode, two 5-bit delay settings, a pulse-width code, two probe enables and the output capture edge. The block also drives a global standby flag and a power state for each user DAC, which combines the register bits with a hardware standby pin. In CCD mode the gain code seen at the output is clipped to its legal ceiling. A control bit in the frame restores every register to its default, and that bit clears itself.

The serial inputs and the standby pin are brought into the system clock domain through synchronizer stages. All logic then runs on that one clock.

Top module: `cfg_serial_port`

## Requirements
- R1: After a synchronous reset (`rst` high), the outputs are: gain 0, both DAC codes 0, black level 0, CCD mode, ADC delay 7, SR delay 9, width code 1, both probe enables low, capture edge rising, standby low (pin high).
- R2: A frame is 16 bits, most significant bit first. The first two bits are ignored, the next four are the address and the last ten are the data. The write takes effect once the 16th bit is sampled.
- R3: When `ser_pol` is 1 the clock rests low and data is sampled on its rising edge. When `ser_pol` is 0 the clock rests high and data is sampled on its falling edge.
- R4: Bits are counted only while `ser_sel_n` is low, and the count restarts each time select goes low. A frame cut short by select rising writes nothing. Bits after the 16th are ignored until select rises.
- R5: Address map and decoding:
  - Address 1 holds the gain code.
  - Addresses 2 and 3 hold the DAC codes in data bits 7..0; bits 9..8 are dropped.
  - Address 6 holds the mode in bit 1 (1 = video).
  - Address 8 holds the ADC delay in bits 9..5 and the SR delay in bits 4..0.
  - Address 9 holds: bit 4 = 1 disables the SR probe, bit 3 = 1 disables the ADC probe, bit 2 = 1 selects falling-edge capture, bits 1..0 = width code.
  - Writes to addresses 4, 7 and 10 to 15 change nothing.
- R6: In CCD mode a stored gain above 767 is presented as 767. In video mode the stored code passes unchanged.
- R7: Address 5 sets the black level. If bit 4 is 1, the level is 20 plus bits 3..0. If bit 4 is 0, the level is 0 whatever bits 3..0 hold.
- R8: `standby` is high when `stby_pin_n` is low or when control bit 9 (address 0) is 1.
- R9: DAC n is on only when its power-down bit (control bit 8 for DAC 1, bit 7 for DAC 2) is 0 and either global standby is off or the sustain bit (control bit 6) is 1.
- R10: A frame to address 0 with data bit 0 set returns every register to its R1 default. The other bits of that frame do not take effect, so the control register ends at 0.
- R11: Frames are accepted and stored while global standby is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; restores defaults |
| ser_pol | input | 1 | Serial clock resting level select (1 = rests low) |
| ser_clk | input | 1 | Serial clock |
| ser_sel_n | input | 1 | Serial select, active low |
| ser_din | input | 1 | Serial data, MSB first |
| stby_pin_n | input | 1 | Hardware standby request, active low |
| standby | output | 1 | Global standby flag |
| dac1_on | output | 1 | User DAC 1 powered |
| dac2_on | output | 1 | User DAC 2 powered |
| dac1_code | output | 8 | User DAC 1 code |
| dac2_code | output | 8 | User DAC 2 code |
| gain_code | output | 10 | Effective gain code after mode clipping |
| video_mode | output | 1 | 1 = video input mode, 0 = CCD mode |
| black_lsb | output | 6 | Black-level target in LSB (0 or 20..35) |
| adc_delay | output | 5 | ADC sampling clock delay step |
| sr_delay | output | 5 | Reference sample delay step |
| sr_width | output | 2 | Reference sample pulse width code |
| sr_out_en | output | 1 | Reference sample probe output enabled |
| adc_out_en | output | 1 | ADC clock probe output enabled |
| latch_on_fall | output | 1 | Output data captured on falling clock edge |

## Verification
The software reset and the ordinary control fields share one register. So a single frame can both request a reset and set standby, sustain and power-down bits in the same commit cycle. The bench sends the value 0x201 to address 0 on top of a fully non-default setup. Reset must win: `standby` stays low, both DACs report on, and every decoded field reads its default. A second collision arises when the hardware standby pin is already low while a sustain or gain frame commits. That case is judged by the DAC power outputs following the combined rule and by the new gain appearing despite standby.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 10;
    localparam int PREFIX_W  = 2;
    localparam int FRAME_W   = PREFIX_W + ADDR_W + DATA_W;
    localparam int NUM_REGS  = 1 << ADDR_W;
    localparam int CNT_W     = $clog2(FRAME_W + 1);
    localparam int NUM_DACS  = 2;
    localparam int DAC_W     = 8;
    localparam int DLY_W     = 5;
    localparam int LVL_W     = 4;
    localparam int BLACK_W   = 6;
    localparam int WID_W     = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam addr_t ADR_CTRL  = 4'd0;
    localparam addr_t ADR_GAIN  = 4'd1;
    localparam addr_t ADR_DAC0  = 4'd2;
    localparam addr_t ADR_BLACK = 4'd5;
    localparam addr_t ADR_VIDEO = 4'd6;
    localparam addr_t ADR_DELAY = 4'd8;
    localparam addr_t ADR_CLOCK = 4'd9;

    // control register bit positions
    localparam int CTRL_STBY  = 9;
    localparam int CTRL_PD0   = 8;  // DAC n power-down sits at CTRL_PD0 - n
    localparam int CTRL_KEEP  = 6;
    localparam int CTRL_SWRST = 0;
    // other field positions
    localparam int VID_MODE   = 1;
    localparam int BLK_EN     = 4;
    localparam int CLK_SR_OFF = 4;
    localparam int CLK_AD_OFF = 3;
    localparam int CLK_FALL   = 2;

    localparam word_t GAIN_CCD_MAX = 10'd767;
    localparam int    BLACK_BASE   = 20;

    typedef struct packed {
        logic [DLY_W-1:0] adc_dly;
        logic [DLY_W-1:0] sr_dly;
        logic [WID_W-1:0] sr_width;
        logic             sr_en;
        logic             adc_en;
        logic             fall_edge;
    } timing_t;

    function automatic logic reg_present(addr_t a);
        case (a)
            ADR_CTRL, ADR_GAIN, ADR_DAC0, ADR_DAC0 + addr_t'(1),
            ADR_BLACK, ADR_VIDEO, ADR_DELAY, ADR_CLOCK: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic word_t reg_default(addr_t a);
        case (a)
            ADR_DELAY: return 10'h0E9;
            ADR_CLOCK: return 10'h039;
            default:   return '0;
        endcase
    endfunction

    function automatic word_t clip_gain(word_t code, logic video);
        return (!video && code > GAIN_CCD_MAX) ? GAIN_CCD_MAX : code;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
    import cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk_s,    // synchronized, normalized: rests low, samples on rise
    input  logic  sdin_s,
    input  logic  sel_n_s,
    output logic  wr_valid,
    output addr_t wr_addr,
    output word_t wr_data
);
    logic               clk_d;
    logic               act_edge;
    logic [FRAME_W-2:0] shreg;
    logic [FRAME_W-1:0] frame_next;
    logic [CNT_W-1:0]   cnt;
    logic               unused_prefix;

    assign act_edge      = sclk_s & ~clk_d;
    assign frame_next    = {shreg, sdin_s};
    assign unused_prefix = ^frame_next[FRAME_W-1 -: PREFIX_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_d    <= 1'b0;
            shreg    <= '0;
            cnt      <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            clk_d    <= sclk_s;
            wr_valid <= 1'b0;
            if (sel_n_s) begin
                cnt <= '0;
            end else if (act_edge && cnt < CNT_W'(FRAME_W)) begin
                shreg <= frame_next[FRAME_W-2:0];
                cnt   <= cnt + 1'b1;
                if (cnt == CNT_W'(FRAME_W - 1)) begin
                    wr_valid <= 1'b1;
                    wr_addr  <= frame_next[DATA_W +: ADDR_W];
                    wr_data  <= frame_next[DATA_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import cfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_valid,
    input  addr_t wr_addr,
    input  word_t wr_data,
    output word_t bank [NUM_REGS]
);
    logic sw_rst;

    // a reset request wins over every field carried in the same frame
    assign sw_rst = wr_valid && (wr_addr == ADR_CTRL) && wr_data[CTRL_SWRST];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        if (reg_present(addr_t'(i))) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst || sw_rst) begin
                    bank[i] <= reg_default(addr_t'(i));
                end else if (wr_valid && wr_addr == addr_t'(i)) begin
                    bank[i] <= wr_data;
                end
            end
        end else begin : g_void
            assign bank[i] = reg_default(addr_t'(i));
        end
    end
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
    import cfg_pkg::*;
(
    input  word_t               bank [NUM_REGS],
    input  logic                stby_pin_n_s,
    output logic                standby,
    output logic [NUM_DACS-1:0] dac_on,
    output logic [DAC_W-1:0]    dac_code [NUM_DACS],
    output word_t               gain_code,
    output logic                video_mode,
    output logic [BLACK_W-1:0]  black_lsb,
    output timing_t             timing
);
    word_t ctrl, blk, vid, dly, ckc;
    logic  keep;
    logic  unused_bits;

    assign ctrl = bank[ADR_CTRL];
    assign blk  = bank[ADR_BLACK];
    assign vid  = bank[ADR_VIDEO];
    assign dly  = bank[ADR_DELAY];
    assign ckc  = bank[ADR_CLOCK];

    assign standby    = !stby_pin_n_s || ctrl[CTRL_STBY];
    assign keep       = ctrl[CTRL_KEEP];
    assign video_mode = vid[VID_MODE];
    assign gain_code  = clip_gain(bank[ADR_GAIN], video_mode);
    assign black_lsb  = blk[BLK_EN]
                      ? BLACK_W'(BLACK_BASE) + BLACK_W'(blk[LVL_W-1:0])
                      : '0;

    for (genvar d = 0; d < NUM_DACS; d++) begin : g_dac
        word_t dreg;
        logic  pd;
        assign dreg        = bank[ADR_DAC0 + addr_t'(d)];
        assign pd          = ctrl[CTRL_PD0 - d];
        assign dac_code[d] = dreg[DAC_W-1:0];
        assign dac_on[d]   = !pd && (!standby || keep);
    end

    assign timing.adc_dly   = dly[DATA_W-1 -: DLY_W];
    assign timing.sr_dly    = dly[DLY_W-1:0];
    assign timing.sr_width  = ckc[WID_W-1:0];
    assign timing.sr_en     = !ckc[CLK_SR_OFF];
    assign timing.adc_en    = !ckc[CLK_AD_OFF];
    assign timing.fall_edge = ckc[CLK_FALL];

    assign unused_bits = ^{ctrl[5:0], blk[DATA_W-1:BLK_EN+1], vid[DATA_W-1:VID_MODE+1],
                           vid[0], ckc[DATA_W-1:CLK_SR_OFF+1],
                           g_dac[0].dreg[DATA_W-1:DAC_W], g_dac[1].dreg[DATA_W-1:DAC_W]};
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_pol,
    input  logic         ser_clk,
    input  logic         ser_sel_n,
    input  logic         ser_din,
    input  logic         stby_pin_n,
    output logic         standby,
    output logic         dac1_on,
    output logic         dac2_on,
    output logic [7:0]   dac1_code,
    output logic [7:0]   dac2_code,
    output logic [9:0]   gain_code,
    output logic         video_mode,
    output logic [5:0]   black_lsb,
    output logic [4:0]   adc_delay,
    output logic [4:0]   sr_delay,
    output logic [1:0]   sr_width,
    output logic         sr_out_en,
    output logic         adc_out_en,
    output logic         latch_on_fall
);
    logic                sclk_norm, sclk_s, sdin_s, sel_n_s, stby_s;
    logic                wr_valid;
    addr_t               wr_addr;
    word_t               wr_data;
    word_t               bank [NUM_REGS];
    logic [NUM_DACS-1:0] dac_on;
    logic [DAC_W-1:0]    dac_code [NUM_DACS];
    timing_t             timing;

    // fold the polarity so the sampling edge is always a rise from rest
    assign sclk_norm = ser_pol ? ser_clk : !ser_clk;

    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
        .clk(clk), .rst(rst), .d(sclk_norm), .q(sclk_s));
    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
        .clk(clk), .rst(rst), .d(ser_din), .q(sdin_s));
    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
        .clk(clk), .rst(rst), .d(ser_sel_n), .q(sel_n_s));
    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_stby (
        .clk(clk), .rst(rst), .d(stby_pin_n), .q(stby_s));

    cfg_frame_rx u_rx (
        .clk(clk), .rst(rst), .sclk_s(sclk_s), .sdin_s(sdin_s), .sel_n_s(sel_n_s),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data));

    cfg_regs u_regs (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .bank(bank));

    cfg_decode u_dec (
        .bank(bank), .stby_pin_n_s(stby_s), .standby(standby), .dac_on(dac_on),
        .dac_code(dac_code), .gain_code(gain_code), .video_mode(video_mode),
        .black_lsb(black_lsb), .timing(timing));

    assign dac1_on       = dac_on[0];
    assign dac2_on       = dac_on[1];
    assign dac1_code     = dac_code[0];
    assign dac2_code     = dac_code[1];
    assign adc_delay     = timing.adc_dly;
    assign sr_delay      = timing.sr_dly;
    assign sr_width      = timing.sr_width;
    assign sr_out_en     = timing.sr_en;
    assign adc_out_en    = timing.adc_en;
    assign latch_on_fall = timing.fall_edge;
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_valid,
    input logic [3:0] wr_addr,
    input logic [9:0] wr_data,
    input logic       sel_n_s,
    input logic [9:0] gain_code,
    input logic [7:0] dac1_code,
    input logic       video_mode,
    input logic [4:0] adc_delay,
    input logic [4:0] sr_delay
);
    // R2: a commit is a single-cycle event
    p_single_commit_r2: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    // R2: without a commit the register-driven outputs hold
    p_hold_without_write_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> ($stable(gain_code) && $stable(dac1_code) && $stable(video_mode)
                       && $stable(adc_delay) && $stable(sr_delay)));

    // R4: a commit follows a cycle with select seen low
    p_commit_needs_select_r4: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(!sel_n_s));

    // R5: DAC 1 code follows a write to its address
    p_dac_load_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr == 4'd2) |=> dac1_code == $past(wr_data[7:0]));

    // R6: gain write in CCD mode is clipped at 767
    p_gain_clip_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr == 4'd1 && !video_mode) |=>
        gain_code == (($past(wr_data) > 10'd767) ? 10'd767 : $past(wr_data)));

    // R10: reset request restores defaults on the next cycle
    p_swreset_defaults_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr == 4'd0 && wr_data[0]) |=>
        (gain_code == 10'd0 && dac1_code == 8'd0 && !video_mode
         && adc_delay == 5'd7 && sr_delay == 5'd9));
endmodule

bind cfg_serial_port cfg_serial_port_chk u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel_n_s(sel_n_s), .gain_code(gain_code), .dac1_code(dac1_code),
    .video_mode(video_mode), .adc_delay(adc_delay), .sr_delay(sr_delay));

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;
    localparam int H = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_pol = 1'b1, ser_clk = 1'b0, ser_sel_n = 1'b1, ser_din = 1'b0;
    logic stby_pin_n = 1'b1;
    logic standby, dac1_on, dac2_on, video_mode, sr_out_en, adc_out_en, latch_on_fall;
    logic [7:0] dac1_code, dac2_code;
    logic [9:0] gain_code;
    logic [5:0] black_lsb;
    logic [4:0] adc_delay, sr_delay;
    logic [1:0] sr_width;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    cfg_serial_port u0 (
        .clk(clk), .rst(rst), .ser_pol(ser_pol), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_din(ser_din), .stby_pin_n(stby_pin_n), .standby(standby), .dac1_on(dac1_on),
        .dac2_on(dac2_on), .dac1_code(dac1_code), .dac2_code(dac2_code),
        .gain_code(gain_code), .video_mode(video_mode), .black_lsb(black_lsb),
        .adc_delay(adc_delay), .sr_delay(sr_delay), .sr_width(sr_width),
        .sr_out_en(sr_out_en), .adc_out_en(adc_out_en), .latch_on_fall(latch_on_fall));

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // shift n bits (MSB of the low n first) as one select window
    task automatic shift_bits(input logic [31:0] bits, input int n, input logic pol);
        logic rest;
        rest = !pol;
        ser_pol = pol;
        ser_clk = rest;
        wait_cyc(H);
        ser_sel_n = 1'b0;
        wait_cyc(H);
        for (int i = n - 1; i >= 0; i--) begin
            ser_din = bits[i];
            wait_cyc(H);
            ser_clk = !rest;
            wait_cyc(H);
            ser_clk = rest;
        end
        wait_cyc(H);
        ser_sel_n = 1'b1;
        wait_cyc(3 * H);
    endtask

    task automatic send(input logic [3:0] a, input logic [9:0] d, input logic pol = 1'b1);
        shift_bits({16'h0, 2'b00, a, d}, 16, pol);
    endtask

    task automatic t_reset_state;
        chk("R1 gain", gain_code, 0);
        chk("R1 dac1", dac1_code, 0);
        chk("R1 dac2", dac2_code, 0);
        chk("R1 black", black_lsb, 0);
        chk("R1 mode", video_mode, 0);
        chk("R1 adc_delay", adc_delay, 7);
        chk("R1 sr_delay", sr_delay, 9);
        chk("R1 width", sr_width, 1);
        chk("R1 sr_en", sr_out_en, 0);
        chk("R1 adc_en", adc_out_en, 0);
        chk("R1 edge", latch_on_fall, 0);
        chk("R1 standby", standby, 0);
        chk("R1 dacs on", {dac1_on, dac2_on}, 3);
    endtask

    task automatic t_gain;
        send(4'd1, 10'd300);  chk("R2 gain write", gain_code, 300);
        send(4'd1, 10'd767);  chk("R6 gain 767", gain_code, 767);
        send(4'd1, 10'd768);  chk("R6 gain 768 clipped", gain_code, 767);
        send(4'd1, 10'd1023); chk("R6 gain 1023 clipped", gain_code, 767);
        send(4'd6, 10'h002);  chk("R5 video mode bit", video_mode, 1);
        chk("R6 video passes stored 1023", gain_code, 1023);
        send(4'd1, 10'd900);  chk("R6 video gain 900", gain_code, 900);
        send(4'd6, 10'h001);  chk("R5 mode bit0 ignored", video_mode, 0);
        chk("R6 back to ccd clip", gain_code, 767);
    endtask

    task automatic t_polarity;
        send(4'd2, 10'h0A5, 1'b0); chk("R3 rest-high clock dac1", dac1_code, 8'hA5);
        send(4'd3, 10'h03C, 1'b1); chk("R3 rest-low clock dac2", dac2_code, 8'h3C);
        send(4'd2, 10'h3FF, 1'b0); chk("R5 dac upper bits dropped", dac1_code, 8'hFF);
    endtask

    task automatic t_select;
        shift_bits({16'h0, 2'b00, 4'd2, 10'h011} >> 6, 10, 1'b1);
        chk("R4 short frame 10 bits discarded", dac1_code, 8'hFF);
        shift_bits({16'h0, 2'b00, 4'd2, 10'h011} >> 1, 15, 1'b1);
        chk("R4 short frame 15 bits discarded", dac1_code, 8'hFF);
        send(4'd2, 10'h011);
        chk("R4 count restarts on select", dac1_code, 8'h11);
        shift_bits({12'h0, 2'b00, 4'd2, 10'h055, 4'b1011}, 20, 1'b1);
        chk("R4 extra bits ignored", dac1_code, 8'h55);
    endtask

    task automatic t_reserved;
        send(4'd8, {5'd3, 5'd28});
        send(4'd4, 10'h3FF);
        send(4'd7, 10'h3FF);
        send(4'd12, 10'h3FF);
        send(4'd15, 10'h3FF);
        chk("R5 reserved gain", gain_code, 767);
        chk("R5 reserved dac1", dac1_code, 8'h55);
        chk("R5 reserved dac2", dac2_code, 8'h3C);
        chk("R5 reserved mode", video_mode, 0);
        chk("R5 reserved black", black_lsb, 0);
        chk("R5 reserved clock fields", {sr_out_en, adc_out_en, latch_on_fall, sr_width}, 5'b00001);
        chk("R5 reserved standby", standby, 0);
        chk("R5 adc delay field", adc_delay, 3);
        chk("R5 sr delay field", sr_delay, 28);
        shift_bits({16'h0, 2'b11, 4'd3, 10'h077}, 16, 1'b1);
        chk("R2 prefix bits ignored", dac2_code, 8'h77);
    endtask

    task automatic t_black;
        send(4'd5, 10'h01F); chk("R7 level 35", black_lsb, 35);
        send(4'd5, 10'h010); chk("R7 level 20", black_lsb, 20);
        send(4'd5, 10'h00A); chk("R7 disabled level 0", black_lsb, 0);
        send(4'd5, 10'h3F3); chk("R7 level 23 upper ignored", black_lsb, 23);
    endtask

    task automatic t_clock_ctl;
        send(4'd9, 10'h007);
        chk("R5 clock ctl enables", {sr_out_en, adc_out_en}, 3);
        chk("R5 clock ctl falling edge", latch_on_fall, 1);
        chk("R5 clock ctl width", sr_width, 3);
        send(4'd9, 10'h018);
        chk("R5 clock ctl disables", {sr_out_en, adc_out_en, latch_on_fall, sr_width}, 0);
    endtask

    task automatic t_power;
        send(4'd0, 10'h100);
        chk("R9 pd1 only", {standby, dac1_on, dac2_on}, 3'b001);
        send(4'd0, 10'h200);
        chk("R8 soft standby", {standby, dac1_on, dac2_on}, 3'b100);
        send(4'd0, 10'h240);
        chk("R9 standby with sustain", {standby, dac1_on, dac2_on}, 3'b111);
        send(4'd0, 10'h2C0);
        chk("R9 sustain with pd2", {standby, dac1_on, dac2_on}, 3'b110);
        send(4'd0, 10'h000);
        stby_pin_n = 1'b0;
        wait_cyc(8);
        chk("R8 pin standby", {standby, dac1_on, dac2_on}, 3'b100);
        send(4'd0, 10'h040);
        chk("R9 pin standby sustain", {standby, dac1_on, dac2_on}, 3'b111);
        send(4'd0, 10'h140);
        chk("R9 pin standby sustain pd1", {standby, dac1_on, dac2_on}, 3'b101);
        send(4'd1, 10'd123);
        chk("R11 write during standby", gain_code, 123);
        stby_pin_n = 1'b1;
        wait_cyc(8);
        chk("R8 pin released", standby, 0);
    endtask

    task automatic t_swreset;
        send(4'd6, 10'h002);
        send(4'd1, 10'd500);
        send(4'd0, 10'h3C0);
        chk("R10 setup standby", standby, 1);
        send(4'd0, 10'h201);
        chk("R10 standby cleared", standby, 0);
        chk("R10 dacs on", {dac1_on, dac2_on}, 3);
        chk("R10 gain", gain_code, 0);
        chk("R10 dac1", dac1_code, 0);
        chk("R10 dac2", dac2_code, 0);
        chk("R10 mode", video_mode, 0);
        chk("R10 black", black_lsb, 0);
        chk("R10 delays", {adc_delay, sr_delay}, {5'd7, 5'd9});
        chk("R10 clock ctl", {sr_out_en, adc_out_en, latch_on_fall, sr_width}, 5'b00001);
        send(4'd1, 10'd42);
        chk("R10 writes resume", gain_code, 42);
    endtask

    task automatic t_hw_reset;
        send(4'd8, 10'h000);
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(4);
        chk("R1 hw reset gain", gain_code, 0);
        chk("R1 hw reset delays", {adc_delay, sr_delay}, {5'd7, 5'd9});
    endtask

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(5);
        t_reset_state();
        t_gain();
        t_polarity();
        t_select();
        t_reserved();
        t_black();
        t_clock_ctl();
        t_power();
        t_swreset();
        t_hw_reset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule